// File: doc/BRIEF.md
# Burst SRAM Address Capture and Burst Sequencer

This block sits at the front of a synchronous burst SRAM. It captures a word address on each qualified address strobe and keeps the internal word address that the array logic uses. It also keeps a registered selected flag that tells the read and write paths whether the device is taking part in the current access.

Two active-low strobes can start an access. One comes from the processor side and one from the controller side. The processor strobe has priority, and it only counts when the first chip enable is active. The three chip enables are looked at only on cycles that start an access. Between strobes, an active-low advance input steps a 2-bit burst counter that forms the low two bits of the word address. The counter wraps from 3 to 0 and leaves the upper address bits unchanged.

Top module: `burst_addr_front`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `sel_o` = 0 and `word_addr_o` = 0.
- R2: A load happens when a strobe is effective and the enables sample as `en1_n`=0, `en2`=1, `en3_n`=0. After the load edge, `word_addr_o` equals the `addr_i` sampled at that edge and `sel_o` = 1.
- R3: When `strb_p_n` is low, `en1_n` is high and `strb_c_n` is high, the processor strobe is ignored. The cycle behaves exactly as a cycle with no strobe.
- R4: A strobe that is effective while the enable pattern fails clears `sel_o`. `word_addr_o` keeps its previous value.
- R5: On a cycle with no effective strobe and `adv_n` low, the low two bits of `word_addr_o` increase by 1 modulo 4. The upper bits do not change.
- R6: An effective strobe takes precedence over `adv_n`. No increment happens on a load cycle.
- R7: On a cycle with no effective strobe and `adv_n` high, both `word_addr_o` and `sel_o` hold. This is true whatever the chip enables do.
- R8: When both strobes are low and `en1_n` is low, only the processor strobe is honoured. The result is a single load, identical to a load from either strobe alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | External word address |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| word_addr_o | output | AW | Current internal word address |
| sel_o | output | 1 | Registered selected flag |

## Verification
Every piece of state in this block drives a port directly, one edge after the cycle that sets it. A wrong priority decision, a wrong enable decision or a wrong counter step therefore shows up on `word_addr_o` or `sel_o` at the very next edge. A fault in a hold path, such as enables leaking through on cycles with no strobe, stays visible until the next successful load. The sweeps start each input combination from both a selected state and a deselected state, so that flipped and stuck flags are both exposed.

// File: rtl/burst_addr_front.sv
module burst_addr_front #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          strb_p_n,
  input  logic          strb_c_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  output logic [AW-1:0] word_addr_o,
  output logic          sel_o
);
  localparam int CW = 2;
  localparam int HW = AW - CW;

  logic [HW-1:0] hi_q;
  logic [CW-1:0] cnt_q;
  logic          sel_q;

  wire p_hit = !strb_p_n && !en1_n;
  wire c_hit = !strb_c_n && !p_hit;
  wire load  = p_hit || c_hit;
  wire en_ok = !en1_n && en2 && !en3_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (load) begin
      sel_q <= en_ok;
      if (en_ok) begin
        hi_q  <= addr_i[AW-1:CW];
        cnt_q <= addr_i[CW-1:0];
      end
    end else if (!adv_n) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_addr_o = {hi_q, cnt_q};
  assign sel_o       = sel_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (word_addr_o == '0) && !sel_o);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && (!strb_p_n || !strb_c_n) && !en1_n && en2 && !en3_n)
    |=> (word_addr_o == $past(addr_i)) && sel_o);

  p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !strb_p_n && en1_n && strb_c_n && adv_n)
    |=> $stable(word_addr_o) && $stable(sel_o));

  p_desel_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && ((!strb_p_n && !en1_n) || !strb_c_n) && !(!en1_n && en2 && !en3_n))
    |=> !sel_o && $stable(word_addr_o));

  p_adv_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && strb_c_n && (strb_p_n || en1_n) && !adv_n)
    |=> (word_addr_o[AW-1:CW] == $past(word_addr_o[AW-1:CW])) &&
        (word_addr_o[CW-1:0] == $past(word_addr_o[CW-1:0]) + 2'd1) &&
        $stable(sel_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && strb_c_n && (strb_p_n || en1_n) && adv_n)
    |=> $stable(word_addr_o) && $stable(sel_o));
endmodule

// File: tb/burst_addr_front_tb_top.sv
module burst_addr_front_tb_top;
  localparam int AW = 6;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
  logic en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
  logic [AW-1:0] word_addr_o;
  logic sel_o;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] m_addr = '0;
  logic m_sel = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_front #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .strb_p_n(strb_p_n),
    .strb_c_n(strb_c_n), .adv_n(adv_n), .en1_n(en1_n), .en2(en2),
    .en3_n(en3_n), .word_addr_o(word_addr_o), .sel_o(sel_o)
  );

  task automatic check(input string tag);
    checks++;
    if (word_addr_o !== m_addr || sel_o !== m_sel) begin
      failures++;
      $display("FAIL %s: addr=%0d sel=%0b expected addr=%0d sel=%0b",
               tag, word_addr_o, sel_o, m_addr, m_sel);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic sp, input logic sc,
                     input logic adv, input logic e1, input logic e2,
                     input logic e3, input string tag);
    logic ld, ok;
    addr_i = a; strb_p_n = sp; strb_c_n = sc; adv_n = adv;
    en1_n = e1; en2 = e2; en3_n = e3;
    ld = (!sp && !e1) || !sc;
    ok = !e1 && e2 && !e3;
    if (ld) begin
      m_sel = ok;
      if (ok) m_addr = a;
    end else if (!adv) begin
      m_addr = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    m_addr = '0; m_sel = 1'b0;
    check("R1 reset");
    rst = 1'b0;

    for (int a = 0; a < (1 << AW); a++) begin
      if (a % 2 == 0) cyc(AW'(a), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 processor load");
      else            cyc(AW'(a), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 controller load");
      for (int k = 0; k < 4; k++)
        cyc(AW'(a + 17), 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 advance wrap");
    end

    for (int pre = 0; pre < 2; pre++) begin
      for (int v = 0; v < 64; v++) begin
        logic sp, sc, adv, e1, e2, e3, ld, ok;
        string tag;
        sp = v[0]; sc = v[1]; adv = v[2]; e1 = v[3]; e2 = v[4]; e3 = v[5];
        if (pre == 0) cyc(AW'(v * 5 + 3), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 preset selected");
        else          cyc(AW'(v * 5 + 3), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 preset deselected");
        ld = (!sp && !e1) || !sc;
        ok = !e1 && e2 && !e3;
        if (!sp && !sc && !e1)      tag = "R8 both strobes";
        else if (ld && !ok)         tag = "R4 failed enables";
        else if (ld && !adv)        tag = "R6 strobe beats advance";
        else if (ld)                tag = "R2 load";
        else if (!sp && e1)         tag = "R3 processor strobe ignored";
        else if (!adv)              tag = "R5 advance";
        else                        tag = "R7 hold";
        cyc(AW'(v * 11 + 40), sp, sc, adv, e1, e2, e3, tag);
        cyc(AW'(v + 9), 1'b1, 1'b1, 1'b1, e1, !e2, !e3, "R7 enables ignored without strobe");
      end
    end

    cyc(AW'(21), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 load before reset");
    rst = 1'b1;
    @(posedge clk); #1;
    m_addr = '0; m_sel = 1'b0;
    check("R1 reset mid-run");
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule